// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit register that performs one of four operations on every rising clock edge, chosen by a two-bit mode input. The four operations are hold, shift toward the high end, shift toward the low end, and parallel load. The parallel data terminals form a single shared bidirectional bus. The block drives the register contents onto that bus when output is allowed. It releases the bus whenever a parallel load is selected, so that an external source can present the value to capture.

Two active-low output enables gate only the bus drivers. With either enable high, the bus floats, but the register keeps shifting, loading and clearing as usual. Two dedicated serial outputs always show the two end bits and are never released. An active-low clear empties the register at once, without waiting for a clock edge. The release of clear is synchronised: the first rising edge after clear returns high leaves the register at zero.

Bit 0 is the low end and bit 7 is the high end. Shift-right data enters at bit 0; shift-left data enters at bit 7.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_sel = 2'b00, the register keeps its value across any number of rising edges. Bus activity while the bus is released has no effect on it.
- R2: With mode_sel = 2'b01, each rising edge moves every bit one place toward bit 7, and ser_right_in enters bit 0.
- R3: With mode_sel = 2'b10, each rising edge moves every bit one place toward bit 0, and ser_left_in enters bit 7.
- R4: With mode_sel = 2'b11, the block does not drive data_bus, and a rising edge stores the value present on data_bus.
- R5: data_bus carries the register contents (bit i on data_bus[i]) exactly when oe1_n and oe2_n are both low and mode_sel is not 2'b11. Otherwise the bus is released.
- R6: The output enables have no effect on the register: holding, shifting and loading proceed the same whether the bus is driven or released.
- R7: While clear_n is low, all register bits are zero, with or without a clock edge. out_a, out_h and a driven bus then read zero.
- R8: The first rising edge after clear_n returns high leaves the register at zero, whatever the mode. Normal operation resumes on the following edge.
- R9: out_a always equals register bit 0 and out_h always equals register bit 7, including while the bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on its rising edge |
| clear_n | input | 1 | Active-low clear, asynchronous assert, synchronised release |
| mode_sel | input | 2 | Operation: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe1_n | input | 1 | Active-low bus output enable, first of two |
| oe2_n | input | 1 | Active-low bus output enable, second of two |
| ser_right_in | input | 1 | Serial data entering bit 0 during shift right |
| ser_left_in | input | 1 | Serial data entering bit 7 during shift left |
| data_bus | inout | 8 | Shared parallel bus: load data in, register contents out |
| out_a | output | 1 | Serial output, register bit 0, always driven |
| out_h | output | 1 | Serial output, register bit 7, always driven |

## Verification
The bench targets the end-bit entries of both shift directions. A design with the directions swapped, or one that dropped the serial input, would walk a wrong bit pattern into out_a and out_h. It checks that the bus is released during load and while either enable is high. It does this by driving a value that differs from the register and reading it back; a design still driving would corrupt that readback or load its own contents. It applies clear between clock edges and then loads on the first edge after release. A design with a synchronous clear would show stale data before the edge, and one without the release stage would capture the load value. Noise on the released bus during hold, and shifting with the bus disabled, expose any design that lets the enables or the bus reach the register.

// File: rtl/usr_pkg.sv
// Package usr_pkg
// Shared mode encoding for the universal shift register.
// Assumes the two-bit mode input follows this encoding exactly.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
// Module usr_ctrl
// Decodes the mode input and forms the bus drive enable. It also
// holds the clear-release stage: the flag is set at once by clear and
// drops one rising edge after clear is released. While the flag is
// set, the register does not update.
// Assumes clear_n may change at any time relative to clk.
module usr_ctrl
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      clear_n,
    input  logic [1:0] mode_sel,
    input  logic      oe1_n,
    input  logic      oe2_n,
    output usr_mode_e mode,
    output logic      run,
    output logic      bus_drive_en
);
    logic release_hold_q;

    // Cast the raw select lines onto the shared mode type
    always_comb begin
        mode = usr_mode_e'(mode_sel);
    end

    // Clear-release stage: set by clear, cleared by the first edge after it
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            release_hold_q <= 1'b1;
        end else begin
            release_hold_q <= 1'b0;
        end
    end

    // Register may update only once the release stage has passed
    always_comb begin
        run = !release_hold_q;
    end

    // Bus is driven only with both enables low and no load selected
    always_comb begin
        bus_drive_en = !oe1_n && !oe2_n && (mode != MODE_LOAD);
    end
endmodule

// File: rtl/usr_core.sv
// Module usr_core
// The storage bits and their per-bit next-state selection. Bit 0 takes
// the right serial input in shift right; bit WIDTH-1 takes the left
// serial input in shift left.
// Assumes run is low on the first edge after clear release.
module usr_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             run,
    input  usr_mode_e        mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] load_d,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] q_next;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;

        // Pick the neighbour toward bit 0 (serial right input at the end)
        if (i == 0) begin : g_low_end
            always_comb from_low = ser_r;
        end else begin : g_low_mid
            always_comb from_low = q[i-1];
        end

        // Pick the neighbour toward the top bit (serial left input at the end)
        if (i == MSB) begin : g_high_end
            always_comb from_high = ser_l;
        end else begin : g_high_mid
            always_comb from_high = q[i+1];
        end

        // Per-bit mode multiplexer
        always_comb begin
            unique case (mode)
                MODE_HOLD: q_next[i] = q[i];
                MODE_SHR:  q_next[i] = from_low;
                MODE_SHL:  q_next[i] = from_high;
                MODE_LOAD: q_next[i] = load_d[i];
                default:   q_next[i] = q[i];
            endcase
        end
    end

    // Storage: cleared at once by clear, updated on edges while running
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            q <= '0;
        end else if (run) begin
            q <= q_next;
        end
    end

    // R1
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (run && mode == MODE_HOLD) |=> (q == $past(q)));

    // R2
    shift_right_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (run && mode == MODE_SHR) |=>
            (q[0] == $past(ser_r)) && (q[MSB:1] == $past(q[MSB-1:0])));

    // R3
    shift_left_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (run && mode == MODE_SHL) |=>
            (q[MSB] == $past(ser_l)) && (q[MSB-1:0] == $past(q[MSB:1])));

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (run && mode == MODE_LOAD) |=> (q == $past(load_d)));

    // R8
    release_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!run) |=> (q == '0));
endmodule

// File: rtl/usr_bus.sv
// Module usr_bus
// Tristate driver and read path for the shared parallel bus.
// Assumes any external driver stays off while drive_en is high.
module usr_bus #(
    parameter int WIDTH = 8
) (
    inout  wire  [WIDTH-1:0] bus,
    input  logic             drive_en,
    input  logic [WIDTH-1:0] data_o,
    output logic [WIDTH-1:0] data_i
);
    // Drive the register value or release the bus
    assign bus = drive_en ? data_o : {WIDTH{1'bz}};

    // Internal read path used for loading
    assign data_i = bus;
endmodule

// File: rtl/usr_shift_reg.sv
// Module usr_shift_reg
// Universal shift register with a shared bidirectional parallel bus.
// Four operations are selected by mode_sel. Two active-low enables
// gate only the bus drivers, and the two end bits have dedicated
// serial outputs that are always driven. clear_n is the block's own
// clear: it asserts asynchronously and releases on a clock edge.
// Assumes external bus drivers are active only while the block releases.
module usr_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic [1:0]       mode_sel,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    inout  wire  [WIDTH-1:0] data_bus,
    output logic             out_a,
    output logic             out_h
);
    import usr_pkg::*;

    localparam int MSB = WIDTH - 1;

    usr_mode_e        mode;
    logic             run;
    logic             bus_drive_en;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] bus_rd;

    usr_ctrl i_ctrl (
        .clk          (clk),
        .clear_n      (clear_n),
        .mode_sel     (mode_sel),
        .oe1_n        (oe1_n),
        .oe2_n        (oe2_n),
        .mode         (mode),
        .run          (run),
        .bus_drive_en (bus_drive_en)
    );

    usr_core #(.WIDTH(WIDTH)) i_core (
        .clk     (clk),
        .clear_n (clear_n),
        .run     (run),
        .mode    (mode),
        .ser_r   (ser_right_in),
        .ser_l   (ser_left_in),
        .load_d  (bus_rd),
        .q       (q)
    );

    usr_bus #(.WIDTH(WIDTH)) i_bus (
        .bus      (data_bus),
        .drive_en (bus_drive_en),
        .data_o   (q),
        .data_i   (bus_rd)
    );

    // Serial outputs show the end bits at all times
    always_comb begin
        out_a = q[0];
        out_h = q[MSB];
    end

    // R5
    bus_shows_reg_chk: assert property (@(posedge clk) disable iff (!clear_n)
        bus_drive_en |-> (bus_rd == q));
endmodule

// File: tb/test_usr_shift_reg.sv
// Bench for usr_shift_reg: a behavioural reference model stepped once
// per clock, compared mid-cycle and after every rising edge.
module test_usr_shift_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       oe1_n = 1'b1;
    logic       oe2_n = 1'b1;
    logic       ser_right_in = 1'b0;
    logic       ser_left_in = 1'b0;
    wire  [7:0] data_bus;
    logic       out_a;
    logic       out_h;

    logic       tb_en = 1'b0;
    logic [7:0] tb_val = 8'h00;
    assign data_bus = tb_en ? tb_val : 8'bzzzzzzzz;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_q = 8'h00;
    bit         m_wait = 1'b1;
    bit         m_released = 1'b1;

    usr_shift_reg i_usr_shift_reg (
        .clk          (clk),
        .clear_n      (clear_n),
        .mode_sel     (mode_sel),
        .oe1_n        (oe1_n),
        .oe2_n        (oe2_n),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .data_bus     (data_bus),
        .out_a        (out_a),
        .out_h        (out_h)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        logic [7:0] exp_bus;
        exp_bus = m_released ? tb_val : m_q;
        check(data_bus === exp_bus, req, "data_bus", data_bus, exp_bus);
        check(out_a === m_q[0], req, "out_a", {7'd0, out_a}, {7'd0, m_q[0]});
        check(out_h === m_q[7], req, "out_h", {7'd0, out_h}, {7'd0, m_q[7]});
    endtask

    // One clock: drive inputs while clk is low, check, edge, check again
    task automatic step(input logic [1:0] md, input bit o1, input bit o2,
                        input bit sr, input bit sl, input bit c_n,
                        input logic [7:0] ld, input string req);
        mode_sel = md;
        oe1_n = o1;
        oe2_n = o2;
        ser_right_in = sr;
        ser_left_in = sl;
        clear_n = c_n;
        m_released = o1 || o2 || (md == 2'b11);
        if (m_released) begin
            tb_en = 1'b1;
            tb_val = (md == 2'b11) ? ld : ~m_q;
        end else begin
            tb_en = 1'b0;
        end
        #1;
        if (!c_n) begin
            m_q = 8'h00;
            m_wait = 1'b1;
        end
        compare(req);
        @(posedge clk);
        if (!c_n) begin
            m_q = 8'h00;
            m_wait = 1'b1;
        end else if (m_wait) begin
            m_wait = 1'b0;
        end else begin
            case (md)
                2'b01: m_q = {m_q[6:0], sr};
                2'b10: m_q = {sl, m_q[7:1]};
                2'b11: m_q = ld;
                default: m_q = m_q;
            endcase
        end
        #2;
        compare(req);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R7: reset state, cleared register with and without enables
        step(2'b00, 1, 1, 0, 0, 0, 8'h00, "R7");
        step(2'b00, 0, 0, 0, 0, 0, 8'h00, "R7");
        // R8: load requested on the first edge after release is ignored
        step(2'b11, 0, 0, 0, 0, 1, 8'hFF, "R8");
        // R4: load with bus released and enables low
        step(2'b11, 0, 0, 0, 0, 1, 8'hA5, "R4");
        step(2'b00, 0, 0, 0, 0, 1, 8'h00, "R5");
        // R1: hold for several edges, with noise on the released bus
        for (int k = 0; k < 4; k++) step(2'b00, 1, 0, 1, 1, 1, 8'h00, "R1");
        for (int k = 0; k < 3; k++) step(2'b00, 0, 0, 1, 1, 1, 8'h00, "R1");
        // R2: shift right a pattern through
        for (int k = 0; k < 9; k++)
            step(2'b01, 0, 0, k[0] ^ k[2], 0, 1, 8'h00, "R2");
        // R3: shift left a pattern through
        for (int k = 0; k < 9; k++)
            step(2'b10, 0, 0, 0, k[1], 1, 8'h00, "R3");
        // R6: shift and load while each enable disables the bus
        step(2'b11, 0, 0, 0, 0, 1, 8'h3C, "R4");
        for (int k = 0; k < 3; k++) step(2'b01, 1, 0, 1, 0, 1, 8'h00, "R6");
        for (int k = 0; k < 2; k++) step(2'b10, 0, 1, 0, 1, 1, 8'h00, "R6");
        step(2'b11, 1, 1, 0, 0, 1, 8'h81, "R6");
        // R9: serial outputs while the bus floats
        step(2'b00, 1, 1, 0, 0, 1, 8'h00, "R9");
        step(2'b00, 0, 0, 0, 0, 1, 8'h00, "R5");
        // R7: clear mid-operation, visible before any edge
        step(2'b01, 0, 0, 1, 0, 0, 8'h00, "R7");
        step(2'b01, 0, 0, 1, 0, 1, 8'h00, "R8");
        step(2'b01, 0, 0, 1, 0, 1, 8'h00, "R2");
        // Mixed traffic across all modes and enables
        for (int k = 0; k < 300; k++) begin
            logic [1:0] md;
            logic [7:0] d;
            bit c;
            md = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            c = ($urandom_range(0, 40) != 0);
            step(md, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 c, d, "R5");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule